// File: doc/BRIEF.md
# Sample Receive FIFO with Register Port

This block sits at the back end of a multi-channel audio capture path. A decimation stage upstream hands it one 24-bit sample at a time, together with the index of the channel the sample belongs to. The block queues the samples and tags each stored word with its channel index. Software or a DMA engine drains the queue through one receive data register on a 32-bit register port that follows APB timing: a setup cycle, then an access cycle, with no wait states.

Around the queue the block holds several registers. A mode word and a configuration word are stored here and driven out unchanged to the filter and pin logic. There is a write-only control word for software reset, and a read-only version word. Interrupts use separate set and clear registers for the mask, a read-back of the mask, and a status word whose error bits clear when the word is read.

The mode word also sets a burst size. A DMA request, and the matching status bit, are raised while at least that many words are waiting. A sample that arrives while the queue is full is dropped and counted as an overrun. A read from the empty queue is counted as an underrun and returns the last word that was delivered.

Top module: `smp_rx_port`

## Requirements
- R1: After reset the status word (offset 0x20) reads 0x02 (only the empty bit set), the mode, configuration and mask reads are zero, and both `irq` and `dma_req` are low.
- R2: Reading offset 0x0C removes the oldest queued word and returns it as {channel index zero-extended into bits 31:24, sample in bits 23:0}, in arrival order.
- R3: A sample offered while the queue holds DEPTH words, with no receive read in the same access cycle, is dropped and sets status bit 5. A sample offered in the same cycle as a receive read of a full queue is accepted.
- R4: A read of offset 0x0C while the queue is empty returns the last word removed (zero after any reset), leaves the queue empty and sets status bit 4.
- R5: Status bit 0 means not empty, bit 1 empty and bit 2 full, all live. Reading offset 0x20 clears bits 4 and 5, unless a new event of the same kind occurs in that cycle.
- R6: Mode bits 31:28 give a burst threshold N, where 0 counts as 1. Status bit 3 and `dma_req` are high while the queue holds at least N words.
- R7: Writing offset 0x14 sets the mask bits that are 1 in bits 5:0. Writing 0x18 clears them. Offset 0x1C reads the mask in bits 5:0. `irq` is high exactly when status AND mask is non-zero.
- R8: Offsets 0x04 (mode) and 0x08 (configuration) are 32-bit read/write registers and drive `mode_word` and `cfg_word`.
- R9: Writing 1 in bit 0 of offset 0x00 empties the queue and clears the error bits, the mask, the mode, the configuration and the held last word. Writing 0 there has no effect, and offset 0x00 reads zero.
- R10: Offset 0x50 reads VERSION in bits 11:0 with zeros above, and writes to it are ignored. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | Register port select |
| penable | input | 1 | Access phase of the register port |
| pwrite | input | 1 | 1 for a write, 0 for a read |
| paddr | input | ADDR_W | Byte offset of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during the access phase |
| smp_valid | input | 1 | A sample is offered this cycle |
| smp_chan | input | CH_W | Channel index of the offered sample |
| smp_data | input | SMP_W | Offered sample |
| mode_word | output | 32 | Stored mode word for the other blocks |
| cfg_word | output | 32 | Stored configuration word for the other blocks |
| dma_req | output | 1 | Burst threshold reached |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach is a full queue that receives a new sample in the same cycle as a receive read. The overrun decision then depends on a read and a push landing on one clock edge. The bench first fills the queue past its depth, so that real overruns occur. It then issues a receive read whose access phase carries a sample on the sample input. The reference model decides acceptance by the same rule, from the requirement. Read-clear races and the held underrun value are reached by reading status and receive registers straight after draining or after a software reset.

// File: rtl/smp_rx_pkg.sv
package smp_rx_pkg;
    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_MODE = 8'h04;
    localparam logic [7:0] OFS_CFG  = 8'h08;
    localparam logic [7:0] OFS_RXD  = 8'h0C;
    localparam logic [7:0] OFS_IEN  = 8'h14;
    localparam logic [7:0] OFS_IDIS = 8'h18;
    localparam logic [7:0] OFS_IMSK = 8'h1C;
    localparam logic [7:0] OFS_STAT = 8'h20;
    localparam logic [7:0] OFS_VER  = 8'h50;

    localparam int NUM_FLAGS = 6;
    localparam int NUM_LIVE  = 4;

    typedef struct packed {
        logic [31:0] mode;
        logic [31:0] cfg;
        logic [31:0] last;
    } ctl_regs_t;
endpackage

// File: rtl/smp_rx_queue.sv
module smp_rx_queue #(
    parameter int DEPTH = 16,
    parameter int W     = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full,
    output logic          ovr_evt,
    output logic          udr_evt
);
    typedef struct packed {
        logic [AW-1:0] rd;
        logic [AW-1:0] wr;
        logic [CW-1:0] cnt;
    } q_state_t;

    q_state_t s_d, s_q;
    logic [W-1:0] mem [DEPTH];
    logic do_push, do_pop;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (s_q.cnt == '0);
    assign full    = (s_q.cnt == CW'(DEPTH));
    assign count   = s_q.cnt;
    assign dout    = mem[s_q.rd];
    assign ovr_evt = push && full && !pop;
    assign udr_evt = pop && empty;

    always_comb begin
        s_d     = s_q;
        do_pop  = pop && !empty;
        do_push = push && (!full || pop);
        if (clr) begin
            s_d = '0;
        end else begin
            if (do_push) s_d.wr = nxt(s_q.wr);
            if (do_pop)  s_d.rd = nxt(s_q.rd);
            if (do_push && !do_pop)      s_d.cnt = s_q.cnt + 1'b1;
            else if (!do_push && do_pop) s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[s_q.wr] <= din;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CW'(DEPTH)); // R3
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clr) |=> full); // R3
    AST_EMPTY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push && !clr) |=> empty); // R4
endmodule

// File: rtl/smp_rx_flags.sv
module smp_rx_flags
    import smp_rx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 ien_wr,
    input  logic                 idis_wr,
    input  logic [NUM_FLAGS-1:0] wmask,
    input  logic                 stat_rd,
    input  logic                 ovr_evt,
    input  logic                 udr_evt,
    input  logic [NUM_LIVE-1:0]  live,
    output logic [NUM_FLAGS-1:0] mask,
    output logic [NUM_FLAGS-1:0] status,
    output logic                 irq
);
    typedef struct packed {
        logic [NUM_FLAGS-1:0] mask;
        logic                 ovr;
        logic                 udr;
    } f_state_t;

    f_state_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (clr) begin
            f_d = '0;
        end else begin
            if (ien_wr)  f_d.mask = f_d.mask | wmask;
            if (idis_wr) f_d.mask = f_d.mask & ~wmask;
            f_d.ovr = (f_q.ovr && !stat_rd) || ovr_evt;
            f_d.udr = (f_q.udr && !stat_rd) || udr_evt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign mask   = f_q.mask;
    assign status = {f_q.ovr, f_q.udr, live};
    assign irq    = |(status & f_q.mask);

    AST_OVR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[5]) |-> $past(ovr_evt)); // R3
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !ovr_evt && !udr_evt) |=> (status[5:4] == 2'b00)); // R5
    AST_IEN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_wr && !idis_wr && !clr) |=> ((mask & $past(wmask)) == $past(wmask))); // R7
endmodule

// File: rtl/smp_rx_port.sv
module smp_rx_port
    import smp_rx_pkg::*;
#(
    parameter int          DEPTH   = 16,
    parameter int          ADDR_W  = 8,
    parameter int          CH_W    = 2,
    parameter int          SMP_W   = 24,
    parameter logic [11:0] VERSION = 12'h1A3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    input  logic              smp_valid,
    input  logic [CH_W-1:0]   smp_chan,
    input  logic [SMP_W-1:0]  smp_data,
    output logic [31:0]       mode_word,
    output logic [31:0]       cfg_word,
    output logic              dma_req,
    output logic              irq
);
    localparam int TAG_W = 32 - SMP_W;
    localparam int CW    = $clog2(DEPTH + 1);

    ctl_regs_t r_d, r_q;

    logic wr_acc, rd_acc, soft_clr, rx_rd, stat_rd;
    logic [31:0] q_head;
    logic [CW-1:0] q_count;
    logic q_empty, q_full, q_ovr, q_udr;
    logic [3:0] chunk_thr;
    logic chunk_hit;
    logic [NUM_FLAGS-1:0] msk, st;

    assign wr_acc   = psel && penable && pwrite;
    assign rd_acc   = psel && penable && !pwrite;
    assign soft_clr = wr_acc && (paddr == ADDR_W'(OFS_CTRL)) && pwdata[0];
    assign rx_rd    = rd_acc && (paddr == ADDR_W'(OFS_RXD));
    assign stat_rd  = rd_acc && (paddr == ADDR_W'(OFS_STAT));

    smp_rx_queue #(.DEPTH(DEPTH), .W(32)) u_queue (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (soft_clr),
        .push    (smp_valid),
        .pop     (rx_rd),
        .din     ({TAG_W'(smp_chan), smp_data}),
        .dout    (q_head),
        .count   (q_count),
        .empty   (q_empty),
        .full    (q_full),
        .ovr_evt (q_ovr),
        .udr_evt (q_udr)
    );

    assign chunk_thr = (r_q.mode[31:28] == 4'd0) ? 4'd1 : r_q.mode[31:28];
    assign chunk_hit = 32'(q_count) >= 32'(chunk_thr);

    smp_rx_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (soft_clr),
        .ien_wr  (wr_acc && (paddr == ADDR_W'(OFS_IEN))),
        .idis_wr (wr_acc && (paddr == ADDR_W'(OFS_IDIS))),
        .wmask   (pwdata[NUM_FLAGS-1:0]),
        .stat_rd (stat_rd),
        .ovr_evt (q_ovr),
        .udr_evt (q_udr),
        .live    ({chunk_hit, q_full, q_empty, !q_empty}),
        .mask    (msk),
        .status  (st),
        .irq     (irq)
    );

    always_comb begin
        r_d = r_q;
        if (soft_clr) begin
            r_d = '0;
        end else begin
            if (wr_acc && (paddr == ADDR_W'(OFS_MODE))) r_d.mode = pwdata;
            if (wr_acc && (paddr == ADDR_W'(OFS_CFG)))  r_d.cfg  = pwdata;
            if (rx_rd && !q_empty)                      r_d.last = q_head;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (paddr)
            ADDR_W'(OFS_MODE): prdata = r_q.mode;
            ADDR_W'(OFS_CFG):  prdata = r_q.cfg;
            ADDR_W'(OFS_RXD):  prdata = q_empty ? r_q.last : q_head;
            ADDR_W'(OFS_IMSK): prdata = {{(32-NUM_FLAGS){1'b0}}, msk};
            ADDR_W'(OFS_STAT): prdata = {{(32-NUM_FLAGS){1'b0}}, st};
            ADDR_W'(OFS_VER):  prdata = {20'd0, VERSION};
            default:           prdata = 32'd0;
        endcase
    end

    assign mode_word = r_q.mode;
    assign cfg_word  = r_q.cfg;
    assign dma_req   = chunk_hit;

    AST_UNDERRUN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd && q_empty) |=> st[4]); // R4
    AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (q_empty && (mode_word == 32'd0) && !irq)); // R9
    AST_UNDERRUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd && q_empty && !smp_valid) |=> $stable(r_q.last)); // R4
endmodule

// File: tb/smp_rx_port_bench.sv
module smp_rx_port_bench;
    localparam int DEPTH = 16;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0;
    logic psel = 0, penable = 0, pwrite = 0;
    logic [7:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic smp_valid = 0;
    logic [1:0] smp_chan = '0;
    logic [23:0] smp_data = '0;
    logic [31:0] mode_word, cfg_word;
    logic dma_req, irq;

    smp_rx_port u_smp_rx_port (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .smp_valid(smp_valid),
        .smp_chan(smp_chan), .smp_data(smp_data), .mode_word(mode_word),
        .cfg_word(cfg_word), .dma_req(dma_req), .irq(irq)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // reference model state
    logic [31:0] mq[$];
    bit m_ovr, m_udr;
    logic [5:0] m_mask;
    logic [31:0] m_mode, m_cfg, m_last;
    bit e_ovr, e_udr, was_full, popr, wr_c, rd_c;

    function automatic logic [5:0] m_status();
        int thr;
        thr = (m_mode[31:28] == 0) ? 1 : int'(m_mode[31:28]);
        return {m_ovr, m_udr, (mq.size() >= thr), (mq.size() == DEPTH),
                (mq.size() == 0), (mq.size() != 0)};
    endfunction

    function automatic logic [31:0] m_rdata(input logic [7:0] a);
        case (a)
            8'h04: return m_mode;
            8'h08: return m_cfg;
            8'h0C: return (mq.size() != 0) ? mq[0] : m_last;
            8'h1C: return {26'd0, m_mask};
            8'h20: return {26'd0, m_status()};
            8'h50: return 32'h0000_01A3;
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete(); m_ovr = 0; m_udr = 0; m_mask = '0;
            m_mode = '0; m_cfg = '0; m_last = '0;
        end else begin
            wr_c = psel && penable && pwrite;
            rd_c = psel && penable && !pwrite;
            if (wr_c && paddr == 8'h00 && pwdata[0]) begin
                mq.delete(); m_ovr = 0; m_udr = 0; m_mask = '0;
                m_mode = '0; m_cfg = '0; m_last = '0;
            end else begin
                e_ovr = 0; e_udr = 0;
                was_full = (mq.size() == DEPTH);
                popr = rd_c && paddr == 8'h0C;
                if (popr) begin
                    if (mq.size() != 0) m_last = mq.pop_front();
                    else e_udr = 1;
                end
                if (smp_valid) begin
                    if (!was_full || popr) mq.push_back({6'd0, smp_chan, smp_data});
                    else e_ovr = 1;
                end
                if (rd_c && paddr == 8'h20) begin m_ovr = 0; m_udr = 0; end
                m_ovr = m_ovr | e_ovr;
                m_udr = m_udr | e_udr;
                if (wr_c) begin
                    case (paddr)
                        8'h04: m_mode = pwdata;
                        8'h08: m_cfg = pwdata;
                        8'h14: m_mask = m_mask | pwdata[5:0];
                        8'h18: m_mask = m_mask & ~pwdata[5:0];
                        default: ;
                    endcase
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R6 dma_req", {31'd0, dma_req}, {31'd0, m_status()[3]});
            chk("R7 irq", {31'd0, irq}, {31'd0, |(m_status() & m_mask)});
            chk("R8 mode_word", mode_word, m_mode);
            chk("R8 cfg_word", cfg_word, m_cfg);
        end
    end

    task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_rd(input logic [7:0] a, input string tag,
                          input bit with_push = 0, input logic [1:0] ch = 0,
                          input logic [23:0] d = 0);
        @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge clk); penable = 1;
        if (with_push) begin smp_valid = 1; smp_chan = ch; smp_data = d; end
        #1;
        chk(tag, prdata, m_rdata(a));
        @(negedge clk); psel = 0; penable = 0; smp_valid = 0;
    endtask

    task automatic push(input logic [1:0] ch, input logic [23:0] d);
        @(negedge clk); smp_valid = 1; smp_chan = ch; smp_data = d;
        @(negedge clk); smp_valid = 0;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog act=running exp=finished");
            done = 1;
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        // R1 reset state
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 dma_req", {31'd0, dma_req}, 32'd0);
        apb_rd(8'h20, "R1 status");
        chk("R1 status literal", prdata, 32'h2);
        apb_rd(8'h04, "R1 mode");
        apb_rd(8'h1C, "R1 mask");
        // R8 mode/config
        apb_wr(8'h04, 32'h4000_00F3);
        apb_wr(8'h08, 32'h00A5_5A01);
        apb_rd(8'h04, "R8 mode rd");
        apb_rd(8'h08, "R8 cfg rd");
        // R6 threshold 4
        push(2'd0, 24'h111111);
        push(2'd1, 24'h222222);
        push(2'd2, 24'h333333);
        apb_rd(8'h20, "R6 below threshold");
        push(2'd3, 24'h123456);
        apb_rd(8'h20, "R6 at threshold");
        // R2 order and tag
        apb_rd(8'h0C, "R2 pop0");
        apb_rd(8'h0C, "R2 pop1");
        apb_rd(8'h0C, "R2 pop2");
        apb_rd(8'h0C, "R2 pop3");
        chk("R2 tag literal", prdata, 32'h0312_3456);
        // R4 underrun
        apb_rd(8'h0C, "R4 underrun data");
        apb_rd(8'h20, "R5 udr set");
        apb_rd(8'h20, "R5 udr cleared");
        // R3 overflow
        for (int i = 0; i < DEPTH + 2; i++) push(2'(i % 4), 24'(i * 24'h10101));
        apb_rd(8'h20, "R3 ovr status");
        apb_rd(8'h0C, "R3 pop with push when full", 1, 2'd1, 24'hABCDEF);
        apb_rd(8'h20, "R3 after accepted push");
        for (int i = 0; i < DEPTH; i++) apb_rd(8'h0C, "R2 drain");
        apb_rd(8'h20, "R5 live empty");
        // R7 mask and irq
        apb_wr(8'h14, 32'h22);
        apb_rd(8'h1C, "R7 mask set");
        push(2'd2, 24'h00BEEF);
        apb_wr(8'h14, 32'h01);
        apb_wr(8'h18, 32'h02);
        apb_rd(8'h1C, "R7 mask after clear");
        // R6 chunk zero and eight
        apb_wr(8'h04, 32'h0000_0000);
        apb_rd(8'h20, "R6 chunk zero");
        apb_wr(8'h04, 32'h8000_0000);
        apb_rd(8'h20, "R6 chunk eight");
        // R9 soft reset
        apb_wr(8'h08, 32'h5555_AAAA);
        apb_wr(8'h00, 32'h0);
        apb_rd(8'h20, "R9 zero write no effect");
        apb_rd(8'h08, "R9 cfg kept");
        apb_wr(8'h00, 32'h1);
        apb_rd(8'h20, "R9 status after reset");
        apb_rd(8'h04, "R9 mode cleared");
        apb_rd(8'h1C, "R9 mask cleared");
        apb_rd(8'h0C, "R9 last cleared");
        apb_rd(8'h00, "R9 ctrl reads zero");
        // R10 version and unmapped
        apb_rd(8'h50, "R10 version");
        apb_wr(8'h50, 32'hFFFF_FFFF);
        apb_rd(8'h50, "R10 version after write");
        apb_rd(8'h40, "R10 unmapped");
        repeat (2) @(negedge clk);
        done = 1;
        summary();
        $finish;
    end
endmodule